// File: doc/BRIEF.md
# Serial Port Controller with Guarded Configuration

This block is a byte-oriented asynchronous serial transmitter and receiver behind a 32-bit word-addressed register port. Software writes a byte to the send register to launch a frame on `txd`. Frames arriving on `rxd` are decoded and held in the receive register. Completion, overrun, framing and parity events are held as sticky flags, and each flag is cleared by writing a one to its bit. Two of these flags can be routed to the interrupt line.

Frame format changes are guarded. The controller leaves reset in a setup state. Software asks for or leaves that state through a request bit, and a state field reports when the request has taken effect. Word length, parity and the serial-mode switch are taken only while that field shows setup. The serial-mode switch must be turned on by a write of its own before any other control bit will stick. Both shift engines stay disabled while in setup.

Each bit lasts a fixed number of clock cycles, set by a parameter (default 16). A frame carries one start bit, 7 or 8 data bits sent LSB first, an optional parity bit and one stop bit.

Top module: `uart_ctrl`

## Requirements
- R1: After reset the request register (0x00) reads 1, the state field (bits 15:12 of 0x08) reads 4'b0001, control (0x10), status (0x14) and interrupt enables (0x04) read 0, `txd` is 1 and `irq` is 0.
- R2: Writing bit 0 of 0x00 sets or clears the setup request. The state field changes on the second clock edge after the write: 4'b0001 means setup and 4'b0010 means running.
- R3: Control bits 0 (serial mode), 1 and 7 (word length), 2 (parity enable), 3 and 6 (parity type) change only on a write made while the state field reads 4'b0001. In the running state, writes leave them unchanged.
- R4: While control bit 0 is 0, a write to 0x10 can set only bit 0. Once bit 0 is 1, bits 5 (receive enable) and 4 (send enable) can be written in either state.
- R5: A frame is a low start bit, the data bits LSB first, a parity bit when bit 2 is set, and a high stop bit, each held BIT_CYCLES clocks. Word length {bit7,bit1} = 00 gives 7 data bits and any other value gives 8. The line idles high.
- R6: Parity type bit 3 = 0 gives even parity over the data bits and bit 3 = 1 gives odd parity.
- R7: A write to 0x38 sends its low byte only when serial mode and send are enabled, the state is running and no frame is in flight. Status bit 1 sets after the stop bit ends. A write in setup sends nothing.
- R8: A completed frame whose receive buffer is free stores its data in 0x3C (bit 7 reads 0 for 7-bit frames) and sets status bits 2 and 9. It also sets bit 8 if the stop bit was low and bit 10 if the parity check failed.
- R9: A break (all bits low, including the stop bit) reads as data 0 with status bit 8 set. The receiver then waits for the line to go high before it accepts a new start bit.
- R10: A frame that completes while status bit 9 is set sets bit 7, and the earlier byte in 0x3C is kept.
- R11: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. Bits 13:10 clear together.
- R12: `irq` is high exactly when (enable bit 2 and status bit 2) or (enable bit 1 and status bit 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Interrupt request |

## Verification
The bench probes the one-cycle lag between the setup request and the state field. It writes the format immediately after requesting setup, and a design that checks the request instead of the confirmed state would accept a format that should have been dropped. It drives a break longer than one frame and clears the flags while the line is still low. A receiver that re-arms on a low line would log a phantom zero byte when the line is released. It also sends a second byte into an unread buffer, which catches a design that overwrites the first byte or forgets the overrun flag. Odd and even parity in both word lengths catch a parity bit at the wrong position or with the wrong sense.

// File: rtl/uart_ctrl_pkg.sv
package uart_ctrl_pkg;

    // control register bit positions
    localparam int CR_UART = 0;
    localparam int CR_WL0  = 1;
    localparam int CR_PCE  = 2;
    localparam int CR_PC0  = 3;
    localparam int CR_TXEN = 4;
    localparam int CR_RXEN = 5;
    localparam int CR_PC1  = 6;
    localparam int CR_WL1  = 7;

    // status register bit positions
    localparam int SR_DTF = 1;
    localparam int SR_DRF = 2;
    localparam int SR_BOF = 7;
    localparam int SR_FEF = 8;
    localparam int SR_RMB = 9;
    localparam int SR_PE  = 10;

    localparam logic [3:0] STATE_SETUP = 4'b0001;
    localparam logic [3:0] STATE_RUN   = 4'b0010;

    typedef struct packed {
        logic len8;
        logic par_en;
        logic par_odd;
    } frame_cfg_t;

    typedef struct packed {
        logic       setup_req;
        logic       setup_on;
        logic       uart_on;
        logic       wl1;
        logic       wl0;
        logic       pce;
        logic       pc1;
        logic       pc0;
        logic       txen;
        logic       rxen;
        logic       ie_rx;
        logic       ie_tx;
        logic       f_txdone;
        logic       f_rxdone;
        logic       f_full;
        logic       f_ovr;
        logic       f_frm;
        logic       f_par;
        logic [7:0] rxbuf;
    } regs_t;

    // total bits in a frame: start + data + optional parity + stop
    function automatic logic [3:0] frame_len(input frame_cfg_t c);
        return 4'd9 + {3'b000, c.len8} + {3'b000, c.par_en};
    endfunction

    function automatic logic parity_of(input logic [7:0] d, input frame_cfg_t c);
        logic [7:0] m;
        m = c.len8 ? d : {1'b0, d[6:0]};
        return (^m) ^ c.par_odd;
    endfunction

    // line levels in send order, bit 0 first; unused upper bits are idle high
    function automatic logic [10:0] build_frame(input logic [7:0] d, input frame_cfg_t c);
        logic [10:0] f;
        f    = '1;
        f[0] = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (i < 7 || c.len8) f[i+1] = d[i];
        end
        if (c.par_en) begin
            if (c.len8) f[9] = parity_of(d, c);
            else        f[8] = parity_of(d, c);
        end
        return f;
    endfunction

endpackage

// File: rtl/uart_ctrl_sync.sv
module uart_ctrl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/uart_ctrl_tx.sv
module uart_ctrl_tx
    import uart_ctrl_pkg::*;
#(
    parameter int BIT_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       start,
    input  logic [7:0] data,
    input  frame_cfg_t cfg,
    output logic       txd,
    output logic       busy,
    output logic       done
);
    localparam int CW = $clog2(BIT_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(BIT_CYCLES - 1);

    typedef struct packed {
        logic          busy;
        logic [10:0]   frame;
        logic [3:0]    bit_idx;
        logic [3:0]    nbits;
        logic [CW-1:0] cyc;
    } tx_state_t;

    tx_state_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        done = 1'b0;
        if (!enable) begin
            s_d.busy = 1'b0;
        end else if (!s_q.busy) begin
            if (start) begin
                s_d.busy    = 1'b1;
                s_d.frame   = build_frame(data, cfg);
                s_d.nbits   = frame_len(cfg);
                s_d.bit_idx = '0;
                s_d.cyc     = '0;
            end
        end else if (s_q.cyc == LAST) begin
            s_d.cyc = '0;
            if (s_q.bit_idx == s_q.nbits - 4'd1) begin
                s_d.busy = 1'b0;
                done     = 1'b1;
            end else begin
                s_d.bit_idx = s_q.bit_idx + 4'd1;
                s_d.frame   = {1'b1, s_q.frame[10:1]};
            end
        end else begin
            s_d.cyc = s_q.cyc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.frame <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign txd  = s_q.busy ? s_q.frame[0] : 1'b1;
    assign busy = s_q.busy;

    // a frame always opens with a low start bit
    p_start_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.busy) |-> !txd);

    // the bit pointer never runs past the frame length
    p_idx_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> (s_q.bit_idx < s_q.nbits));
endmodule

// File: rtl/uart_ctrl_rx.sv
module uart_ctrl_rx
    import uart_ctrl_pkg::*;
#(
    parameter int BIT_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       rxd,
    input  frame_cfg_t cfg,
    output logic       done,
    output logic [7:0] data,
    output logic       perr,
    output logic       ferr
);
    localparam int CW = $clog2(BIT_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(BIT_CYCLES - 1);
    localparam logic [CW-1:0] MID  = CW'(BIT_CYCLES / 2 - 1);

    typedef enum logic [1:0] {RX_IDLE, RX_RUN, RX_WAITHI} rx_st_e;

    typedef struct packed {
        rx_st_e        st;
        logic [CW-1:0] cyc;
        logic [3:0]    bit_idx;
        logic [8:0]    bits;
    } rx_state_t;

    rx_state_t s_d, s_q;
    logic [3:0] nbits;
    logic       rx_par;

    assign nbits = frame_len(cfg);

    always_comb begin
        s_d  = s_q;
        done = 1'b0;
        if (!enable) begin
            s_d.st = RX_IDLE;
        end else begin
            unique case (s_q.st)
                RX_IDLE: begin
                    if (!rxd) begin
                        s_d.st      = RX_RUN;
                        s_d.cyc     = '0;
                        s_d.bit_idx = '0;
                    end
                end
                RX_RUN: begin
                    s_d.cyc = (s_q.cyc == LAST) ? '0 : s_q.cyc + 1'b1;
                    if (s_q.cyc == MID) begin
                        if (s_q.bit_idx == 4'd0) begin
                            if (rxd) s_d.st = RX_IDLE;
                            else     s_d.bit_idx = 4'd1;
                        end else if (s_q.bit_idx == nbits - 4'd1) begin
                            done   = 1'b1;
                            s_d.st = rxd ? RX_IDLE : RX_WAITHI;
                        end else begin
                            s_d.bits[s_q.bit_idx - 4'd1] = rxd;
                            s_d.bit_idx = s_q.bit_idx + 4'd1;
                        end
                    end
                end
                RX_WAITHI: begin
                    if (rxd) s_d.st = RX_IDLE;
                end
                default: s_d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: RX_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign data   = cfg.len8 ? s_q.bits[7:0] : {1'b0, s_q.bits[6:0]};
    assign rx_par = cfg.len8 ? s_q.bits[8] : s_q.bits[7];
    assign perr   = cfg.par_en && (rx_par != parity_of(data, cfg));
    assign ferr   = !rxd;

    // after a low stop bit the receiver stays parked while the line is low
    p_hold_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == RX_WAITHI && !rxd && enable) |=> (s_q.st == RX_WAITHI));
endmodule

// File: rtl/uart_ctrl.sv
module uart_ctrl
    import uart_ctrl_pkg::*;
#(
    parameter int BIT_CYCLES = 16,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              rxd,
    output logic              txd,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_REQ  = ADDR_W'('h00);
    localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'('h04);
    localparam logic [ADDR_W-1:0] A_STA  = ADDR_W'('h08);
    localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'('h10);
    localparam logic [ADDR_W-1:0] A_FLG  = ADDR_W'('h14);
    localparam logic [ADDR_W-1:0] A_SEND = ADDR_W'('h38);
    localparam logic [ADDR_W-1:0] A_RECV = ADDR_W'('h3C);

    regs_t      r_d, r_q;
    frame_cfg_t cfg;
    logic       wr_en, tx_start, tx_busy, tx_done, tx_active;
    logic       rx_s, rx_active, rx_done, rx_perr, rx_ferr;
    logic [7:0] rx_data;
    logic       unused_wdata;

    assign unused_wdata = ^bus_wdata[31:14];
    assign wr_en     = bus_sel && bus_wr;
    assign cfg       = '{len8: r_q.wl1 | r_q.wl0, par_en: r_q.pce, par_odd: r_q.pc0};
    assign tx_active = r_q.uart_on && r_q.txen && !r_q.setup_on;
    assign rx_active = r_q.uart_on && r_q.rxen && !r_q.setup_on;

    always_comb begin
        r_d      = r_q;
        tx_start = 1'b0;
        r_d.setup_on = r_q.setup_req;
        if (wr_en) begin
            case (bus_addr)
                A_REQ: r_d.setup_req = bus_wdata[0];
                A_IEN: begin
                    r_d.ie_rx = bus_wdata[2];
                    r_d.ie_tx = bus_wdata[1];
                end
                A_CTL: begin
                    if (r_q.setup_on) r_d.uart_on = bus_wdata[CR_UART];
                    if (r_q.uart_on) begin
                        r_d.txen = bus_wdata[CR_TXEN];
                        r_d.rxen = bus_wdata[CR_RXEN];
                        if (r_q.setup_on) begin
                            r_d.wl1 = bus_wdata[CR_WL1];
                            r_d.wl0 = bus_wdata[CR_WL0];
                            r_d.pce = bus_wdata[CR_PCE];
                            r_d.pc1 = bus_wdata[CR_PC1];
                            r_d.pc0 = bus_wdata[CR_PC0];
                        end
                    end
                end
                A_FLG: begin
                    if (bus_wdata[SR_DTF]) r_d.f_txdone = 1'b0;
                    if (bus_wdata[SR_DRF]) r_d.f_rxdone = 1'b0;
                    if (bus_wdata[SR_RMB]) r_d.f_full   = 1'b0;
                    if (bus_wdata[SR_BOF]) r_d.f_ovr    = 1'b0;
                    if (bus_wdata[SR_FEF]) r_d.f_frm    = 1'b0;
                    if (|bus_wdata[SR_PE+3:SR_PE]) r_d.f_par = 1'b0;
                end
                A_SEND: tx_start = tx_active && !tx_busy;
                default: ;
            endcase
        end
        if (tx_done) r_d.f_txdone = 1'b1;
        if (rx_done) begin
            if (r_q.f_full) begin
                r_d.f_ovr = 1'b1;
            end else begin
                r_d.rxbuf    = rx_data;
                r_d.f_rxdone = 1'b1;
                r_d.f_full   = 1'b1;
                if (rx_ferr) r_d.f_frm = 1'b1;
                if (rx_perr) r_d.f_par = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q           <= '0;
            r_q.setup_req <= 1'b1;
            r_q.setup_on  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_REQ: bus_rdata[0] = r_q.setup_req;
            A_IEN: begin
                bus_rdata[2] = r_q.ie_rx;
                bus_rdata[1] = r_q.ie_tx;
            end
            A_STA: bus_rdata[15:12] = r_q.setup_on ? STATE_SETUP : STATE_RUN;
            A_CTL: begin
                bus_rdata[CR_UART] = r_q.uart_on;
                bus_rdata[CR_WL0]  = r_q.wl0;
                bus_rdata[CR_PCE]  = r_q.pce;
                bus_rdata[CR_PC0]  = r_q.pc0;
                bus_rdata[CR_TXEN] = r_q.txen;
                bus_rdata[CR_RXEN] = r_q.rxen;
                bus_rdata[CR_PC1]  = r_q.pc1;
                bus_rdata[CR_WL1]  = r_q.wl1;
            end
            A_FLG: begin
                bus_rdata[SR_DTF] = r_q.f_txdone;
                bus_rdata[SR_DRF] = r_q.f_rxdone;
                bus_rdata[SR_BOF] = r_q.f_ovr;
                bus_rdata[SR_FEF] = r_q.f_frm;
                bus_rdata[SR_RMB] = r_q.f_full;
                bus_rdata[SR_PE]  = r_q.f_par;
            end
            A_RECV: bus_rdata[7:0] = r_q.rxbuf;
            default: ;
        endcase
    end

    assign irq = (r_q.ie_rx && r_q.f_rxdone) || (r_q.ie_tx && r_q.f_txdone);

    uart_ctrl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rx_s)
    );

    uart_ctrl_tx #(.BIT_CYCLES(BIT_CYCLES)) u_tx (
        .clk(clk), .rst_n(rst_n), .enable(tx_active), .start(tx_start),
        .data(bus_wdata[7:0]), .cfg(cfg), .txd(txd), .busy(tx_busy), .done(tx_done)
    );

    uart_ctrl_rx #(.BIT_CYCLES(BIT_CYCLES)) u_rx (
        .clk(clk), .rst_n(rst_n), .enable(rx_active), .rxd(rx_s), .cfg(cfg),
        .done(rx_done), .data(rx_data), .perr(rx_perr), .ferr(rx_ferr)
    );

    // format fields are frozen unless the confirmed state is setup
    p_cfg_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.setup_on |=> $stable({r_q.uart_on, r_q.wl1, r_q.wl0, r_q.pce, r_q.pc1, r_q.pc0}));

    // confirmed state follows the request one edge later
    p_state_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.setup_req |=> r_q.setup_on);

    // send-complete only rises at the end of a frame in flight
    p_txdone_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.f_txdone) |-> $past(tx_busy));

    // a frame landing on a full buffer leaves the held byte alone
    p_overrun_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && r_q.f_full) |=> $stable(r_q.rxbuf));

    // no enables, no interrupt
    p_irq_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.ie_rx && !r_q.ie_tx) |-> !irq);
endmodule

// File: tb/test_uart_ctrl.sv
`timescale 1ns/1ps
module test_uart_ctrl;
    localparam int BC = 16;
    localparam logic [7:0] A_REQ = 8'h00, A_IEN = 8'h04, A_STA = 8'h08, A_CTL = 8'h10,
                           A_FLG = 8'h14, A_SEND = 8'h38, A_RECV = 8'h3C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rxd = 1'b1;
    logic        txd, irq;

    int n_vec = 0, n_fail = 0;
    bit mon_go = 1'b0;
    bit done_flag = 1'b0;

    logic [10:0] q_bits[$];
    int          q_len[$];
    string       q_tag[$];

    always #2.5 clk = ~clk;

    uart_ctrl #(.BIT_CYCLES(BC)) i_uart_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rxd(rxd), .txd(txd), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    function automatic logic [10:0] mk(input logic [7:0] d, input int nd, input bit pe,
                                      input bit odd, output int n);
        logic [10:0] f;
        logic p;
        f = '1; f[0] = 1'b0; p = odd;
        for (int i = 0; i < nd; i++) begin
            f[i+1] = d[i];
            p ^= d[i];
        end
        if (pe) f[nd+1] = p;
        n = 2 + nd + (pe ? 1 : 0);
        return f;
    endfunction

    // driver: predict the frame, queue it, launch it, wait for completion
    task automatic send(input string tag, input logic [7:0] d, input int nd, input bit pe, input bit odd);
        int n;
        logic [10:0] f;
        logic [31:0] v;
        bit seen;
        f = mk(d, nd, pe, odd, n);
        q_bits.push_back(f); q_len.push_back(n); q_tag.push_back(tag);
        wr(A_SEND, {24'h0, d});
        seen = 1'b0;
        for (int k = 0; k < 400 && !seen; k++) begin
            rd(A_FLG, v);
            seen = v[1];
        end
        chk("R7 send-complete flag", {31'h0, seen}, 32'h1);
    endtask

    task automatic drive(input logic [10:0] f, input int n);
        for (int i = 0; i < n; i++) begin
            rxd = f[i];
            repeat (BC) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    // monitor: decode each frame on txd and compare against the queue
    initial begin
        wait (mon_go);
        forever begin
            logic [10:0] got, exp, mask;
            int n;
            string tag;
            @(negedge txd);
            if (q_bits.size() == 0) begin
                exp = '0; n = 10; tag = "R7 unexpected frame";
            end else begin
                exp = q_bits.pop_front(); n = q_len.pop_front(); tag = q_tag.pop_front();
            end
            got = '1;
            repeat (BC/2) @(negedge clk);
            got[0] = txd;
            for (int i = 1; i < n; i++) begin
                repeat (BC) @(negedge clk);
                got[i] = txd;
            end
            mask = 11'((1 << n) - 1);
            if (tag == "R7 unexpected frame") chk(tag, 32'h1, 32'h0);
            else chk(tag, {21'h0, got & mask}, {21'h0, exp & mask});
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
    end

    initial begin
        logic [31:0] v;
        logic [10:0] f;
        int n;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        mon_go = 1'b1;

        // R1 reset state
        rd(A_REQ, v); chk("R1 request", v, 32'h1);
        rd(A_STA, v); chk("R1 state field", v, 32'h1000);
        rd(A_CTL, v); chk("R1 control", v, 32'h0);
        rd(A_FLG, v); chk("R1 status", v, 32'h0);
        rd(A_IEN, v); chk("R1 enables", v, 32'h0);
        chk("R1 txd idle", {31'h0, txd}, 32'h1);
        chk("R1 irq", {31'h0, irq}, 32'h0);

        // R4 serial-mode gate
        wr(A_CTL, 32'h3E); rd(A_CTL, v); chk("R4 bits ignored while mode off", v, 32'h0);
        wr(A_CTL, 32'h3F); rd(A_CTL, v); chk("R4 only mode bit taken", v, 32'h1);
        wr(A_CTL, 32'h33); rd(A_CTL, v); chk("R3 format accepted in setup", v, 32'h33);

        // R7 nothing sent in setup
        wr(A_SEND, 32'h55);
        repeat (40) @(negedge clk);
        chk("R7 no frame in setup", {31'h0, txd}, 32'h1);
        rd(A_FLG, v); chk("R7 no flag in setup", v & 32'h2, 32'h0);

        // R2 handshake lag
        wr(A_REQ, 32'h0);
        rd(A_STA, v); chk("R2 state lags one edge", v, 32'h1000);
        rd(A_STA, v); chk("R2 running state", v, 32'h2000);

        // R3 format locked while running, R4 enables still writable
        wr(A_CTL, 32'h07); rd(A_CTL, v); chk("R3 format locked", v, 32'h03);
        wr(A_CTL, 32'h33); rd(A_CTL, v); chk("R4 enables writable running", v, 32'h33);

        // R5 8-bit frames, R12 interrupt, R11 write-one-to-clear
        wr(A_IEN, 32'h2);
        send("R5 8N1 A5", 8'hA5, 8, 1'b0, 1'b0);
        chk("R12 irq on send-complete", {31'h0, irq}, 32'h1);
        wr(A_FLG, 32'h0); rd(A_FLG, v); chk("R11 zero write keeps flag", v & 32'h2, 32'h2);
        wr(A_FLG, 32'h2); rd(A_FLG, v); chk("R11 one clears flag", v, 32'h0);
        chk("R12 irq drops", {31'h0, irq}, 32'h0);
        send("R5 8N1 00", 8'h00, 8, 1'b0, 1'b0); wr(A_FLG, 32'h2);
        send("R5 8N1 FF", 8'hFF, 8, 1'b0, 1'b0); wr(A_FLG, 32'h2);

        // R3 write before state confirms is dropped; then 7-bit even
        wr(A_REQ, 32'h1);
        wr(A_CTL, 32'h35); rd(A_CTL, v); chk("R3 write before confirm dropped", v, 32'h33);
        rd(A_STA, v); chk("R2 setup state", v, 32'h1000);
        wr(A_CTL, 32'h35); rd(A_CTL, v); chk("R3 7E1 accepted", v, 32'h35);
        wr(A_REQ, 32'h0); rd(A_STA, v); rd(A_STA, v);
        send("R6 7E1 53", 8'h53, 7, 1'b1, 1'b0); wr(A_FLG, 32'h2);
        send("R6 7E1 FF", 8'hFF, 7, 1'b1, 1'b0); wr(A_FLG, 32'h2);

        // 8-bit odd
        wr(A_REQ, 32'h1); rd(A_STA, v);
        wr(A_CTL, 32'h3F);
        wr(A_REQ, 32'h0); rd(A_STA, v); rd(A_STA, v);
        send("R6 8O1 C3", 8'hC3, 8, 1'b1, 1'b1); wr(A_FLG, 32'h2);

        // R8 receive
        wr(A_IEN, 32'h4);
        f = mk(8'h5A, 8, 1'b1, 1'b1, n); drive(f, n);
        rd(A_FLG, v); chk("R8 receive flags", v, 32'h204);
        rd(A_RECV, v); chk("R8 receive data", v, 32'h5A);
        chk("R12 irq on receive", {31'h0, irq}, 32'h1);

        // R10 overrun
        f = mk(8'h3C, 8, 1'b1, 1'b1, n); drive(f, n);
        rd(A_FLG, v); chk("R10 overrun flag", v, 32'h284);
        rd(A_RECV, v); chk("R10 earlier byte kept", v, 32'h5A);
        wr(A_FLG, 32'hFFFF); rd(A_FLG, v); chk("R11 clear all", v, 32'h0);

        // R8 parity error
        f = mk(8'h96, 8, 1'b1, 1'b1, n); f[9] = ~f[9]; drive(f, n);
        rd(A_FLG, v); chk("R8 parity error flag", v, 32'h604);
        rd(A_RECV, v); chk("R8 data with parity error", v, 32'h96);
        wr(A_FLG, 32'hFFFF);

        // R8 framing error
        f = mk(8'h21, 8, 1'b1, 1'b1, n); f[10] = 1'b0; drive(f, n);
        rd(A_FLG, v); chk("R8 framing error flag", v & 32'h304, 32'h304);
        rd(A_RECV, v); chk("R8 data with framing error", v, 32'h21);
        wr(A_FLG, 32'hFFFF);

        // R9 break, then re-arm only on a high line
        rxd = 1'b0;
        repeat (11*BC + 48) @(negedge clk);
        rd(A_FLG, v); chk("R9 break framing flag", v & 32'h104, 32'h104);
        rd(A_RECV, v); chk("R9 break data zero", v, 32'h0);
        wr(A_FLG, 32'hFFFF);
        repeat (3*BC) @(negedge clk);
        rxd = 1'b1;
        repeat (3*BC) @(negedge clk);
        rd(A_FLG, v); chk("R9 no phantom frame", v, 32'h0);

        repeat (20) @(negedge clk);
        chk("R5 all frames observed", q_bits.size(), 32'h0);
        report();
    end
endmodule